// File: doc/BRIEF.md
# Fault-Bypass Cell Remapping Engine

This block holds the logical index map of a small regular array of processing cells. Each cell holds one pair of logical coordinates. The ring of cells around the edge of the array starts empty and serves as spare capacity. The array stays in service while it is being repaired. When a cell is declared faulty, the engine receives the fault coordinate and the coordinate of an empty cell. It then moves logical indices along an L-shaped route between the two, so that the faulty cell ends up empty and every working index still lives in exactly one place.

The route has two straight legs. The first leg runs along the row of the empty cell: it starts at the empty cell's column and moves toward the fault's column. The second leg runs along the fault's column: it starts at the empty cell's row and moves toward the fault's row. Each clock moves one index into an adjacent cell. The source copy is left in place until the next step overwrites it. A final cycle clears the faulty cell. This ordering means no index is ever missing from the map. A read port lets the surrounding logic look up any cell at any time. The engine reports whether it is busy, gives a one-cycle completion pulse, and reports how many copy steps the last remap took.

Top module: `remap_engine`

## Requirements
- R1: After synchronous reset, every cell at row r, column c with 1 ≤ r ≤ 4 and 1 ≤ c ≤ 4 holds the pair x=c, y=r. All other cells hold x=0, y=0. busy, done and cmd_err are low, and move_count is 0.
- R2: A command is refused if any coordinate is 6 or more, or if the chosen empty cell does not hold (0,0). A refused command raises cmd_err for exactly the one cycle after it is presented, leaves busy low and leaves the map unchanged.
- R3: Rows grow southward and columns grow eastward. The first leg works in the empty cell's row. It starts at the empty cell's column and steps one column toward the fault's column, stopping one short of it. Each visited cell takes the value of its neighbour on the fault side. When the columns are equal, the leg is empty.
- R4: The second leg starts only after the first has finished. It works in the fault's column, starting at the empty cell's row and stepping toward the fault's row, stopping one short of it. Each visited cell takes the value of its neighbour on the fault side.
- R5: After a remap, the faulty cell holds (0,0). Every nonzero pair present before the command appears exactly once in the map.
- R6: When done is high, move_count equals |spare column − fault column| + |spare row − fault row|. done is a single-cycle pulse, and busy is low in that cycle.
- R7: Each busy cycle performs exactly one copy between two cells that share an edge, or the single final clear. busy stays high for move_count + 1 cycles.
- R8: While busy is high, a command is ignored: there is no cmd_err and no effect on the map. A command presented in the cycle where done is high is accepted.
- R9: A command whose fault coordinate equals its empty-cell coordinate makes zero copies. It leaves the map unchanged and completes after one busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_fault_row | input | 3 | Row of the faulty cell |
| cmd_fault_col | input | 3 | Column of the faulty cell |
| cmd_spare_row | input | 3 | Row of the empty cell to absorb the shift |
| cmd_spare_col | input | 3 | Column of the empty cell |
| rd_row | input | 3 | Lookup row |
| rd_col | input | 3 | Lookup column |
| rd_pair_x | output | 3 | x index held by the looked-up cell |
| rd_pair_y | output | 3 | y index held by the looked-up cell |
| busy | output | 1 | Remap in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle refusal pulse |
| move_count | output | 4 | Copy steps of the current or last remap |

## Verification
Two things can meet in the same cycle: the completion of one remap and the arrival of the next command. The bench raises a new command in exactly the cycle where done is high. It then judges the result from the final map, which must match both remaps applied in sequence, and from a second scoreboard entry whose copy count and busy length must match. The opposite case is a command that lands in the middle of a remap. That command must produce neither a refusal pulse nor any trace in the map or in the counts.

// File: rtl/remap_pkg.sv
package remap_pkg;

    parameter int ROWS = 6;
    parameter int COLS = 6;

    localparam int DIM_MAX = (ROWS > COLS) ? ROWS : COLS;
    localparam int AW      = $clog2(DIM_MAX);
    localparam int MAXMV   = ROWS + COLS - 2;
    localparam int MW      = $clog2(MAXMV + 1);

    typedef logic [AW-1:0] coord_t;
    typedef logic [MW-1:0] mcnt_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } cell_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HORZ,
        PH_VERT,
        PH_VACATE
    } phase_t;

    typedef struct packed {
        logic  legal;
        logic  east;
        logic  south;
        mcnt_t hlen;
        mcnt_t vlen;
    } plan_t;

    function automatic cell_t home_pair(input int r, input int c);
        cell_t v;
        v = '0;
        if (r >= 1 && r <= ROWS - 2 && c >= 1 && c <= COLS - 2) begin
            v.x = coord_t'(c);
            v.y = coord_t'(r);
        end
        return v;
    endfunction

    function automatic mcnt_t span(input coord_t a, input coord_t b);
        if (a > b) return mcnt_t'(a - b);
        return mcnt_t'(b - a);
    endfunction

endpackage

// File: rtl/remap_planner.sv
module remap_planner
    import remap_pkg::*;
(
    input  coord_t f_row,
    input  coord_t f_col,
    input  coord_t s_row,
    input  coord_t s_col,
    output plan_t  pl
);

    always_comb begin
        pl.legal = (int'(f_row) < ROWS) && (int'(s_row) < ROWS) &&
                   (int'(f_col) < COLS) && (int'(s_col) < COLS);
        pl.east  = (s_col > f_col);
        pl.south = (s_row >= f_row);
        pl.hlen  = span(s_col, f_col);
        pl.vlen  = span(s_row, f_row);
    end

endmodule

// File: rtl/remap_cell_array.sv
module remap_cell_array
    import remap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cp_en,
    input  coord_t cp_dst_r,
    input  coord_t cp_dst_c,
    input  coord_t cp_src_r,
    input  coord_t cp_src_c,
    input  logic   vac_en,
    input  coord_t vac_r,
    input  coord_t vac_c,
    input  coord_t rd_r,
    input  coord_t rd_c,
    output cell_t  rd_q,
    input  coord_t pk_r,
    input  coord_t pk_c,
    output cell_t  pk_q
);

    cell_t mem [ROWS][COLS];
    cell_t src_val;

    always_comb begin
        src_val = '0;
        rd_q    = '0;
        pk_q    = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (cp_src_r == coord_t'(r) && cp_src_c == coord_t'(c)) src_val = mem[r][c];
                if (rd_r == coord_t'(r) && rd_c == coord_t'(c))         rd_q    = mem[r][c];
                if (pk_r == coord_t'(r) && pk_c == coord_t'(c))         pk_q    = mem[r][c];
            end
        end
    end

    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
        for (genvar gc = 0; gc < COLS; gc++) begin : g_col
            logic hit_cp;
            logic hit_vac;
            assign hit_cp  = cp_en  && cp_dst_r == coord_t'(gr) && cp_dst_c == coord_t'(gc);
            assign hit_vac = vac_en && vac_r    == coord_t'(gr) && vac_c    == coord_t'(gc);
            always_ff @(posedge clk) begin
                if (rst)          mem[gr][gc] <= home_pair(gr, gc);
                else if (hit_cp)  mem[gr][gc] <= src_val;
                else if (hit_vac) mem[gr][gc] <= '0;
            end
        end
    end

    AST_STEP_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        cp_en |-> (span(cp_dst_r, cp_src_r) + span(cp_dst_c, cp_src_c)) == mcnt_t'(1)); // R7
    AST_COPY_OR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(cp_en && vac_en)); // R7
    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (vac_en && rd_r == vac_r && rd_c == vac_c) |=> ($past(rd_r) != rd_r || $past(rd_c) != rd_c || rd_q == '0)); // R5

endmodule

// File: rtl/remap_stepper.sv
module remap_stepper
    import remap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   go_east,
    input  logic   go_south,
    input  mcnt_t  hlen,
    input  mcnt_t  vlen,
    input  coord_t f_row,
    input  coord_t f_col,
    input  coord_t s_row,
    input  coord_t s_col,
    output logic   cp_en,
    output coord_t cp_dst_r,
    output coord_t cp_dst_c,
    output coord_t cp_src_r,
    output coord_t cp_src_c,
    output logic   vac_en,
    output coord_t vac_r,
    output coord_t vac_c,
    output logic   busy,
    output logic   done,
    output mcnt_t  moves
);

    phase_t phase;
    logic   east_q, south_q;
    mcnt_t  hrem, vrem, tot_q;
    coord_t cur, frow_q, fcol_q, srow_q;

    always_comb begin
        cp_en    = 1'b0;
        vac_en   = 1'b0;
        cp_dst_r = '0;
        cp_dst_c = '0;
        cp_src_r = '0;
        cp_src_c = '0;
        vac_r    = frow_q;
        vac_c    = fcol_q;
        case (phase)
            PH_HORZ: begin
                cp_en    = 1'b1;
                cp_dst_r = srow_q;
                cp_dst_c = cur;
                cp_src_r = srow_q;
                cp_src_c = east_q ? coord_t'(cur - 1'b1) : coord_t'(cur + 1'b1);
            end
            PH_VERT: begin
                cp_en    = 1'b1;
                cp_dst_r = cur;
                cp_dst_c = fcol_q;
                cp_src_r = south_q ? coord_t'(cur - 1'b1) : coord_t'(cur + 1'b1);
                cp_src_c = fcol_q;
            end
            PH_VACATE: vac_en = 1'b1;
            default: ;
        endcase
    end

    assign busy = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            done    <= 1'b0;
            moves   <= '0;
            tot_q   <= '0;
            hrem    <= '0;
            vrem    <= '0;
            cur     <= '0;
            east_q  <= 1'b0;
            south_q <= 1'b0;
            frow_q  <= '0;
            fcol_q  <= '0;
            srow_q  <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        east_q  <= go_east;
                        south_q <= go_south;
                        hrem    <= hlen;
                        vrem    <= vlen;
                        tot_q   <= hlen + vlen;
                        frow_q  <= f_row;
                        fcol_q  <= f_col;
                        srow_q  <= s_row;
                        moves   <= '0;
                        if (hlen != '0) begin
                            phase <= PH_HORZ;
                            cur   <= s_col;
                        end else if (vlen != '0) begin
                            phase <= PH_VERT;
                            cur   <= s_row;
                        end else begin
                            phase <= PH_VACATE;
                        end
                    end
                end
                PH_HORZ: begin
                    moves <= moves + 1'b1;
                    hrem  <= hrem - 1'b1;
                    cur   <= east_q ? coord_t'(cur - 1'b1) : coord_t'(cur + 1'b1);
                    if (hrem == mcnt_t'(1)) begin
                        if (vrem != '0) begin
                            phase <= PH_VERT;
                            cur   <= srow_q;
                        end else begin
                            phase <= PH_VACATE;
                        end
                    end
                end
                PH_VERT: begin
                    moves <= moves + 1'b1;
                    vrem  <= vrem - 1'b1;
                    cur   <= south_q ? coord_t'(cur - 1'b1) : coord_t'(cur + 1'b1);
                    if (vrem == mcnt_t'(1)) phase <= PH_VACATE;
                end
                default: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R6
    AST_MOVE_TOTAL: assert property (@(posedge clk) disable iff (rst)
        done |-> moves == tot_q); // R6
    AST_HORZ_FIRST: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_VERT) |-> hrem == '0); // R4
    AST_CUR_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HORZ) |-> int'(cur) < COLS); // R3

endmodule

// File: rtl/remap_engine.sv
module remap_engine
    import remap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_fault_row,
    input  logic [AW-1:0] cmd_fault_col,
    input  logic [AW-1:0] cmd_spare_row,
    input  logic [AW-1:0] cmd_spare_col,
    input  logic [AW-1:0] rd_row,
    input  logic [AW-1:0] rd_col,
    output logic [AW-1:0] rd_pair_x,
    output logic [AW-1:0] rd_pair_y,
    output logic          busy,
    output logic          done,
    output logic          cmd_err,
    output logic [MW-1:0] move_count
);

    plan_t  pl;
    cell_t  rd_q, pk_q;
    logic   start, refuse;
    logic   cp_en, vac_en;
    coord_t cp_dst_r, cp_dst_c, cp_src_r, cp_src_c, vac_r, vac_c;

    remap_planner u_plan (
        .f_row (cmd_fault_row),
        .f_col (cmd_fault_col),
        .s_row (cmd_spare_row),
        .s_col (cmd_spare_col),
        .pl    (pl)
    );

    assign start  = cmd_valid && !busy && pl.legal && (pk_q == '0);
    assign refuse = cmd_valid && !busy && !(pl.legal && (pk_q == '0));

    remap_stepper u_step (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .go_east  (pl.east),
        .go_south (pl.south),
        .hlen     (pl.hlen),
        .vlen     (pl.vlen),
        .f_row    (cmd_fault_row),
        .f_col    (cmd_fault_col),
        .s_row    (cmd_spare_row),
        .s_col    (cmd_spare_col),
        .cp_en    (cp_en),
        .cp_dst_r (cp_dst_r),
        .cp_dst_c (cp_dst_c),
        .cp_src_r (cp_src_r),
        .cp_src_c (cp_src_c),
        .vac_en   (vac_en),
        .vac_r    (vac_r),
        .vac_c    (vac_c),
        .busy     (busy),
        .done     (done),
        .moves    (move_count)
    );

    remap_cell_array u_arr (
        .clk      (clk),
        .rst      (rst),
        .cp_en    (cp_en),
        .cp_dst_r (cp_dst_r),
        .cp_dst_c (cp_dst_c),
        .cp_src_r (cp_src_r),
        .cp_src_c (cp_src_c),
        .vac_en   (vac_en),
        .vac_r    (vac_r),
        .vac_c    (vac_c),
        .rd_r     (rd_row),
        .rd_c     (rd_col),
        .rd_q     (rd_q),
        .pk_r     (cmd_spare_row),
        .pk_c     (cmd_spare_col),
        .pk_q     (pk_q)
    );

    assign rd_pair_x = rd_q.x;
    assign rd_pair_y = rd_q.y;

    always_ff @(posedge clk) begin
        if (rst) cmd_err <= 1'b0;
        else     cmd_err <= refuse;
    end

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !busy); // R2
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cmd_err && !cmd_valid) |=> !cmd_err); // R2
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        busy |=> !cmd_err); // R8

endmodule

// File: tb/tb_remap_engine.sv
module tb_remap_engine;
    import remap_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_fault_row = '0, cmd_fault_col = '0;
    logic [AW-1:0] cmd_spare_row = '0, cmd_spare_col = '0;
    logic [AW-1:0] rd_row = '0, rd_col = '0;
    logic [AW-1:0] rd_pair_x, rd_pair_y;
    logic          busy, done, cmd_err;
    logic [MW-1:0] move_count;

    int checks = 0;
    int errors = 0;
    int ex [ROWS][COLS];
    int ey [ROWS][COLS];
    int exp_q [$];
    int bcnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    remap_engine dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
        .cmd_fault_row(cmd_fault_row), .cmd_fault_col(cmd_fault_col),
        .cmd_spare_row(cmd_spare_row), .cmd_spare_col(cmd_spare_col),
        .rd_row(rd_row), .rd_col(rd_col), .rd_pair_x(rd_pair_x), .rd_pair_y(rd_pair_y),
        .busy(busy), .done(done), .cmd_err(cmd_err), .move_count(move_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // scoreboard monitor: one queue entry per accepted command
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) bcnt++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected done", 1, 0);
                end else begin
                    int m;
                    m = exp_q.pop_front();
                    check(int'(move_count) == m, "R6 move_count", int'(move_count), m);
                    check(bcnt == m + 1, "R7 busy cycles", bcnt, m + 1);
                    check(!busy, "R6 busy low with done", int'(busy), 0);
                end
                bcnt = 0;
            end
        end
    end

    task automatic model_init();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                bit in;
                in = (r >= 1 && r <= ROWS - 2 && c >= 1 && c <= COLS - 2);
                ex[r][c] = in ? c : 0;
                ey[r][c] = in ? r : 0;
            end
    endtask

    task automatic model_move(input int dr, input int dc, input int sr, input int sc);
        ex[dr][dc] = ex[sr][sc];
        ey[dr][dc] = ey[sr][sc];
    endtask

    task automatic model_apply(input int fr, input int fc, input int sr, input int sc);
        if (sc > fc) for (int k = sc; k >= fc + 1; k--) model_move(sr, k, sr, k - 1);
        else if (sc < fc) for (int k = sc; k <= fc - 1; k++) model_move(sr, k, sr, k + 1);
        if (sr >= fr) for (int k = sr; k >= fr + 1; k--) model_move(k, fc, k - 1, fc);
        else for (int k = sr; k <= fr - 1; k++) model_move(k, fc, k + 1, fc);
        ex[fr][fc] = 0;
        ey[fr][fc] = 0;
    endtask

    task automatic check_array(input string req);
        int bad = 0, ax = 0, ay = 0, wx = 0, wy = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                rd_row = AW'(r);
                rd_col = AW'(c);
                #1;
                if (int'(rd_pair_x) != ex[r][c] || int'(rd_pair_y) != ey[r][c]) begin
                    if (bad == 0) begin
                        ax = int'(rd_pair_x) * 10 + int'(rd_pair_y);
                        wx = ex[r][c] * 10 + ey[r][c];
                        ay = r * 10 + c;
                    end
                    bad++;
                end
            end
        wy = ay;
        if (bad != 0) $display("  first mismatch at cell row*10+col=%0d", wy);
        check(bad == 0, req, ax, wx);
        @(negedge clk);
    endtask

    task automatic check_invariant(input int fr, input int fc, input string req);
        int cnt [ROWS][COLS];
        int bad = 0;
        int fz;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) cnt[r][c] = 0;
        fz = 1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                rd_row = AW'(r);
                rd_col = AW'(c);
                #1;
                if (rd_pair_x != '0 || rd_pair_y != '0) begin
                    if (int'(rd_pair_y) < ROWS && int'(rd_pair_x) < COLS)
                        cnt[rd_pair_y][rd_pair_x]++;
                    if (r == fr && c == fc) fz = 0;
                end
            end
        for (int y = 1; y <= ROWS - 2; y++)
            for (int x = 1; x <= COLS - 2; x++)
                if (cnt[y][x] != 1) bad++;
        check(bad == 0, {req, " each index once"}, bad, 0);
        check(fz == 1, {req, " fault cell empty"}, fz, 1);
        @(negedge clk);
    endtask

    task automatic drive(input int fr, input int fc, input int sr, input int sc);
        cmd_fault_row = AW'(fr);
        cmd_fault_col = AW'(fc);
        cmd_spare_row = AW'(sr);
        cmd_spare_col = AW'(sc);
        cmd_valid     = 1'b1;
    endtask

    task automatic run_reject(input int fr, input int fc, input int sr, input int sc, input string req);
        drive(fr, fc, sr, sc);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err == 1'b1, {req, " err raised"}, int'(cmd_err), 1);
        check(busy == 1'b0, {req, " stays idle"}, int'(busy), 0);
        @(negedge clk);
        check(cmd_err == 1'b0, {req, " err one cycle"}, int'(cmd_err), 0);
    endtask

    task automatic run_cmd(input int fr, input int fc, input int sr, input int sc, input bit inject);
        int dh, dv;
        dh = (sc > fc) ? sc - fc : fc - sc;
        dv = (sr > fr) ? sr - fr : fr - sr;
        exp_q.push_back(dh + dv);
        model_apply(fr, fc, sr, sc);
        drive(fr, fc, sr, sc);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (inject) begin
            @(negedge clk);
            drive(1, 1, 0, 1);
            @(negedge clk);
            cmd_valid = 1'b0;
            check(cmd_err == 1'b0, "R8 busy command no err", int'(cmd_err), 0);
        end
        while (done !== 1'b1) @(negedge clk);
    endtask

    initial begin
        model_init();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1 busy/done low", int'(busy) + int'(done), 0);
        check(cmd_err == 1'b0, "R1 err low", int'(cmd_err), 0);
        check(move_count == '0, "R1 move_count zero", int'(move_count), 0);
        check_array("R1 nominal map");

        // R2 refusals
        run_reject(2, 2, 2, 3, "R2 occupied spare");
        run_reject(6, 1, 0, 0, "R2 row out of range");
        run_reject(1, 1, 0, 7, "R2 col out of range");
        check_array("R2 map unchanged");

        // R3/R4 east+south leg, with R8 mid-busy command
        run_cmd(2, 2, 4, 5, 1'b1);
        @(negedge clk);
        check_array("R3 R4 east-south remap, R8 ignored cmd");
        check_invariant(2, 2, "R5 east-south");

        // R3/R4 west+north, then R8 back-to-back in the done cycle
        run_cmd(3, 3, 0, 0, 1'b0);
        run_cmd(1, 4, 1, 5, 1'b0);
        @(negedge clk);
        check_array("R3 R4 R8 west-north then back-to-back");
        check_invariant(1, 4, "R5 back-to-back");

        // R9 coincident fault and spare
        run_cmd(5, 0, 5, 0, 1'b0);
        @(negedge clk);
        check_array("R9 zero-move map unchanged");

        // south-west leg with the spare in the bottom row
        run_cmd(4, 2, 5, 0, 1'b0);
        @(negedge clk);
        check_array("R3 R4 south-west remap");
        check_invariant(4, 2, "R5 south-west");

        check(exp_q.size() == 0, "R6 all completions seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule